// File: doc/BRIEF.md
# Six-Channel PWM with Two Shared Prescalers

The block drives six pulse-width modulated outputs from a single bus clock. Two free-running power-of-two prescalers each make a one-cycle enable pulse. Prescaler A paces channels 0, 1, 4 and 5. Prescaler B paces channels 2 and 3. No derived clock exists: every flop runs on `clk_i` and advances only on its tick.

Each channel has an 8-bit period, an 8-bit duty and an enable. It has one alignment bit that picks one of two modes:
- Edge mode, a sawtooth count.
- Symmetric mode, a count that rises and then falls.

The period, duty and alignment values come from externally held register inputs. Each channel copies them into working registers only when its period ends or while it is disabled, so a rewrite never cuts a pulse short.

Top module: `pwm6_dual_presc`

## Requirements
- R1: While `rst_ni` is low, and after reset with every enable low, all `pwm_o` bits are 0.
- R2: A prescaler select value n (0 to 7) makes its tick once every 2^n bus cycles.
- R3: Channels 0, 1, 4 and 5 advance only on the prescaler A tick (`presc_a_sel_i`). Channels 2 and 3 advance only on the prescaler B tick (`presc_b_sel_i`).
- R4: With `center_en_i[n]`=0 (edge mode), channel n counts 0 to P-1 once per tick and then wraps. Its output is high while the count is below D. The period is P ticks.
- R5: With `center_en_i[n]`=1 (symmetric mode), the count climbs 0 to P and then falls back to 1. Its output is high while the count is below D. The period is 2P ticks.
- R6: A change of period or duty on an enabled channel takes effect only when the current period ends.
- R7: An enable sampled low forces that output to 0 from the next bus cycle. While the channel is disabled, the working registers follow the inputs.
- R8: A change of a channel's alignment bit has no effect while the channel is enabled.
- R9: A channel that becomes enabled starts at count 0 counting up. Its output is high in the first bus cycle after the enabling edge when D>0.
- R10: D=0 gives a constant low output. D>=P gives a constant high output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| presc_a_sel_i | input | 3 | Prescaler A select, rate = bus/2^sel |
| presc_b_sel_i | input | 3 | Prescaler B select, rate = bus/2^sel |
| center_en_i | input | 6 | Bit n=1 puts channel n in symmetric mode |
| ch_en_i | input | 6 | Bit n enables channel n |
| period_i | input | 48 | Channel n period in bits [8n+7:8n] |
| duty_i | input | 48 | Channel n duty in bits [8n+7:8n] |
| pwm_o | output | 6 | PWM outputs, bit n = channel n |

## Verification
Outputs come straight from the channel registers:
- A change of enable is visible in the bus cycle after the edge that samples it.
- With select 0, each count step is visible one cycle after its tick.
- A buffered duty change is visible in the first cycle after the wrap edge.

The bench drives inputs and samples `pwm_o` on falling edges, so each sample sits half a cycle after the edge that produced it. For the step checks of R6 and R9, the bench counts falling edges from the enabling edge. Rate and mode checks run only after a settling delay. They then count high cycles and rising edges over a window that is a whole multiple of the expected period, so the tick phase at enable does not change the totals.

// File: rtl/pwm6_pkg.sv
package pwm6_pkg;
  localparam int NUM_CH   = 6;
  localparam int CNT_W    = 8;
  localparam int PRE_W    = 7;
  localparam int SEL_W    = 3;
  // channels paced by prescaler B; all others use A
  localparam logic [NUM_CH-1:0] SRC_B_MAP = 6'b001100;
endpackage

// File: rtl/pwm6_prescaler.sv
module pwm6_prescaler #(
  parameter int PRE_W = 7,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;

  assign mask   = PRE_W'((PRE_W+1)'(1) << sel_i) - 1'b1;
  assign tick_o = (cnt_q & mask) == mask;

  // R2
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && sel_i != '0 && $stable(sel_i)) |=> !tick_o);
endmodule

// File: rtl/pwm6_channel.sv
module pwm6_channel #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             center_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cnt_q, per_q, duty_q;
  logic             dir_dn_q, center_q, act_q;
  logic [CNT_W:0]   cnt_nx;

  assign cnt_nx = {1'b0, cnt_q} + 9'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; per_q <= '0; duty_q <= '0;
      dir_dn_q <= 1'b0; center_q <= 1'b0; act_q <= 1'b0;
    end else begin
      act_q <= en_i;
      if (!en_i || !act_q) begin
        cnt_q    <= '0;
        dir_dn_q <= 1'b0;
        per_q    <= period_i;
        duty_q   <= duty_i;
        center_q <= center_i;
      end else if (tick_i) begin
        if (!center_q) begin
          if (cnt_nx >= {1'b0, per_q}) begin
            cnt_q  <= '0;
            per_q  <= period_i;
            duty_q <= duty_i;
          end else begin
            cnt_q <= cnt_nx[CNT_W-1:0];
          end
        end else if (!dir_dn_q) begin
          cnt_q <= cnt_nx[CNT_W-1:0];
          if (cnt_nx >= {1'b0, per_q}) dir_dn_q <= 1'b1;
        end else if (cnt_q <= CNT_W'(1)) begin
          cnt_q    <= '0;
          dir_dn_q <= 1'b0;
          per_q    <= period_i;
          duty_q   <= duty_i;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (!act_q || duty_q == '0) pwm_o = 1'b0;
    else if (duty_q >= per_q)    pwm_o = 1'b1;
    else                         pwm_o = cnt_q < duty_q;
  end

  // R7
  off_when_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pwm_o);
  // R6
  buffered_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && en_i && !tick_i) |=> ($stable(per_q) && $stable(duty_q)));
  // R8
  align_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && en_i) |=> $stable(center_q));
  // R4
  edge_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !center_q && per_q != '0) |-> cnt_q < per_q);
  // R5
  sym_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && center_q && per_q != '0) |-> cnt_q <= per_q);
  // R9
  start_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !act_q) |=> (cnt_q == '0 && !dir_dn_q));
endmodule

// File: rtl/pwm6_dual_presc.sv
module pwm6_dual_presc
  import pwm6_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [SEL_W-1:0]        presc_a_sel_i,
  input  logic [SEL_W-1:0]        presc_b_sel_i,
  input  logic [NUM_CH-1:0]       center_en_i,
  input  logic [NUM_CH-1:0]       ch_en_i,
  input  logic [NUM_CH*CNT_W-1:0] period_i,
  input  logic [NUM_CH*CNT_W-1:0] duty_i,
  output logic [NUM_CH-1:0]       pwm_o
);
  logic tick_a, tick_b;

  pwm6_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_presc_a (
    .clk_i, .rst_ni, .sel_i(presc_a_sel_i), .tick_o(tick_a));
  pwm6_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_presc_b (
    .clk_i, .rst_ni, .sel_i(presc_b_sel_i), .tick_o(tick_b));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic tick;
    if (SRC_B_MAP[n]) begin : g_b
      assign tick = tick_b;
    end else begin : g_a
      assign tick = tick_a;
    end
    pwm6_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i, .rst_ni, .tick_i(tick), .en_i(ch_en_i[n]),
      .center_i(center_en_i[n]),
      .period_i(period_i[n*CNT_W +: CNT_W]),
      .duty_i(duty_i[n*CNT_W +: CNT_W]),
      .pwm_o(pwm_o[n]));
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rst_ni) |-> pwm_o == '0);
endmodule

// File: tb/pwm6_dual_presc_tb.sv
module pwm6_dual_presc_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  presc_a_sel_i = '0, presc_b_sel_i = '0;
  logic [5:0]  center_en_i = '0, ch_en_i = '0;
  logic [47:0] period_i = '0, duty_i = '0;
  logic [5:0]  pwm_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  pwm6_dual_presc u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int k = 1);
    for (int i = 0; i < k; i++) @(negedge clk_i);
  endtask

  task automatic cfg(input int ch, input int p, input int d);
    period_i[ch*8 +: 8] = 8'(p);
    duty_i[ch*8 +: 8]   = 8'(d);
  endtask

  task automatic measure(input int ch, input int n, output int hi, output int rises);
    logic prev = pwm_o[ch];
    hi = 0; rises = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (pwm_o[ch]) hi++;
      if (pwm_o[ch] && !prev) rises++;
      prev = pwm_o[ch];
    end
  endtask

  task automatic t_reset();
    step(2);
    check(pwm_o == 6'd0, "R1 in reset", int'(pwm_o), 0);
    rst_ni = 1'b1;
    step(3);
    check(pwm_o == 6'd0, "R1 after reset", int'(pwm_o), 0);
  endtask

  task automatic t_edge_start();
    int hi, r;
    cfg(0, 4, 1); presc_a_sel_i = 3'd0;
    ch_en_i[0] = 1'b1;
    step();
    check(pwm_o[0] == 1'b1, "R9 first cycle high", int'(pwm_o[0]), 1);
    step();
    check(pwm_o[0] == 1'b0, "R9 second cycle low", int'(pwm_o[0]), 0);
    step(6);
    measure(0, 40, hi, r);
    check(hi == 10, "R4 edge highs", hi, 10);
    check(r == 10, "R4 edge period", r, 10);
    center_en_i[0] = 1'b1;
    step(2);
    measure(0, 40, hi, r);
    check(hi == 10, "R8 align ignored while enabled", hi, 10);
    ch_en_i[0] = 1'b0;
    step();
    check(pwm_o[0] == 1'b0, "R7 off after disable", int'(pwm_o[0]), 0);
    center_en_i[0] = 1'b0;
  endtask

  task automatic t_center();
    int hi, r;
    cfg(1, 4, 2); center_en_i[1] = 1'b1; ch_en_i[1] = 1'b1;
    step(8);
    measure(1, 40, hi, r);
    check(hi == 15, "R5 symmetric highs", hi, 15);
    check(r == 5, "R5 symmetric period", r, 5);
    ch_en_i[1] = 1'b0; center_en_i[1] = 1'b0;
    step();
  endtask

  task automatic t_prescale();
    int hi, r;
    presc_a_sel_i = 3'd2; presc_b_sel_i = 3'd0;
    cfg(0, 4, 1); cfg(2, 4, 1);
    ch_en_i[0] = 1'b1; ch_en_i[2] = 1'b1;
    step(20);
    fork
      measure(0, 64, hi, r);
      begin int h2, r2; measure(2, 64, h2, r2);
        check(h2 == 16 && r2 == 16, "R3 ch2 on prescaler B", r2, 16); end
    join
    check(hi == 16, "R2 div4 highs", hi, 16);
    check(r == 4, "R3 ch0 on prescaler A div4", r, 4);
    ch_en_i = '0; step();
    presc_a_sel_i = 3'd7; cfg(4, 2, 1); ch_en_i[4] = 1'b1;
    step(300);
    measure(4, 512, hi, r);
    check(hi == 256 && r == 2, "R2 div128", r, 2);
    ch_en_i = '0; presc_a_sel_i = 3'd0;
    step();
  endtask

  task automatic t_buffer();
    cfg(3, 8, 2); presc_b_sel_i = 3'd0; ch_en_i[3] = 1'b1;
    step(4);
    duty_i[3*8 +: 8] = 8'd6;
    for (int i = 0; i < 5; i++) begin
      check(pwm_o[3] == 1'b0, "R6 old duty kept", int'(pwm_o[3]), 0);
      step();
    end
    for (int i = 0; i < 8; i++) begin
      check(pwm_o[3] == (i < 6), "R6 new duty after wrap", int'(pwm_o[3]), int'(i < 6));
      step();
    end
    ch_en_i[3] = 1'b0;
    step();
  endtask

  task automatic t_extremes();
    int hi, r;
    cfg(5, 5, 0); ch_en_i[5] = 1'b1;
    step(3);
    measure(5, 32, hi, r);
    check(hi == 0, "R10 duty 0 low", hi, 0);
    ch_en_i[5] = 1'b0; step();
    cfg(5, 5, 9); ch_en_i[5] = 1'b1;
    step(3);
    measure(5, 32, hi, r);
    check(hi == 32, "R10 duty over period high", hi, 32);
    ch_en_i[5] = 1'b0; step();
    check(pwm_o[5] == 1'b0, "R7 disabled low", int'(pwm_o[5]), 0);
  endtask

  initial begin
    t_reset();
    t_edge_start();
    t_center();
    t_prescale();
    t_buffer();
    t_extremes();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule